// File: doc/BRIEF.md
# Augmented Effective Address Generator

This block builds a 17-bit operand address for a processor whose words are 18 bits wide but whose instructions hold only a 12-bit address field. The missing five high-order bits, called the page, come from one of two places. One source is a 6-bit bank register held inside the block, made of a control flag and a 5-bit bank value. The other source is the upper five bits of the instruction address register supplied by the core.

A lookup on the 6-bit function code sorts each instruction into one of four classes. The lookup is set by three 64-bit parameter masks. A paged-memory instruction takes its page from the bank value when the control flag is set, and from the instruction address register when it is clear. A fixed-page instruction always takes its page from the instruction address register. An immediate instruction returns its 12-bit field as an operand and produces no address. A three-field instruction returns its minor code and data field and produces no address.

The outputs are combinational from the instruction, the instruction address register and the registered bank register. The core loads the bank register through a synchronous write port.

Top module: `aeag_top`

## Requirements
- R1: The function code is `instr_i[17:12]`. A code whose bit is set in `T3_MASK` is a three-field instruction. Otherwise, a code set in `IMM_MASK` is immediate. Otherwise, a code set in `T1_MASK` is paged-memory. Every remaining code is fixed-page. The defaults are: codes 60 to 63 are three-field, 32 to 39 are immediate, 1 to 31 are paged-memory, and 0 and 40 to 59 are fixed-page.
- R2: For a paged-memory instruction with bank control flag `sr[5]` equal to 1, `ea_o` equals `{sr[4:0], instr_i[11:0]}` and `addr_valid_o` is 1.
- R3: For a paged-memory instruction with `sr[5]` equal to 0, `ea_o` equals `{iar_i[16:12], instr_i[11:0]}` and `addr_valid_o` is 1.
- R4: For a fixed-page instruction, `ea_o` equals `{iar_i[16:12], instr_i[11:0]}` whatever the bank register holds, and `addr_valid_o` is 1.
- R5: For an immediate instruction, `imm_valid_o` is 1, `imm_o` equals `instr_i[11:0]`, `addr_valid_o` is 0 and `ea_o` is 0.
- R6: For a three-field instruction, `is_type3_o` is 1, `t3_minor_o` equals `instr_i[11:6]`, `t3_data_o` equals `instr_i[5:0]`, both valid outputs are 0, and `ea_o` and `imm_o` are 0.
- R7: The bank register is 0 after reset. When `sr_we_i` is high at a rising edge it takes `sr_wdata_i`, and the new value first affects the outputs after that edge. When `sr_we_i` is low it holds its value.
- R8: Exactly one of `addr_valid_o`, `imm_valid_o` and `is_type3_o` is 1. `imm_o`, `t3_minor_o` and `t3_data_o` are 0 unless their own class is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 18 | Current instruction word |
| iar_i | input | 17 | Instruction address register; bits 16:12 form the fallback page |
| sr_we_i | input | 1 | Bank register write enable |
| sr_wdata_i | input | 6 | Bank register write data: bit 5 is the control flag, bits 4:0 are the bank |
| ea_o | output | 17 | Effective address, or 0 when no address is produced |
| addr_valid_o | output | 1 | `ea_o` holds a memory address |
| imm_o | output | 12 | Immediate operand |
| imm_valid_o | output | 1 | `imm_o` holds an operand |
| is_type3_o | output | 1 | Instruction is a three-field instruction |
| t3_minor_o | output | 6 | Minor function of a three-field instruction |
| t3_data_o | output | 6 | Data field of a three-field instruction |

## Verification
The assertions assume that `instr_i` and `iar_i` are stable and known at each rising edge. They also assume that the write data is known whenever `sr_we_i` is high. The stimulus meets both conditions by changing every input only on the falling edge, from known values.

The stimulus draws function codes from all four classes. It sets the control flag both ways through bank writes, which it issues in about one cycle of three. This means writes and the instructions that follow them land in adjacent cycles.

// File: rtl/aeag_pkg.sv
package aeag_pkg;
    localparam int WORD_W  = 18;
    localparam int FUNC_W  = 6;
    localparam int FIELD_W = 12;
    localparam int PAGE_W  = 5;
    localparam int EA_W    = PAGE_W + FIELD_W;
    localparam int SUB_W   = FIELD_W / 2;
    localparam int NCODES  = 1 << FUNC_W;

    typedef enum logic [1:0] {
        CLS_PAGED = 2'd0,
        CLS_FIXED = 2'd1,
        CLS_IMM   = 2'd2,
        CLS_TRI   = 2'd3
    } cls_e;

    typedef struct packed {
        logic              ctl;
        logic [PAGE_W-1:0] bank;
    } bankreg_t;
endpackage

// File: rtl/aeag_classify.sv
module aeag_classify
    import aeag_pkg::*;
#(
    parameter logic [NCODES-1:0] T1_MASK  = 64'h0000_0000_FFFF_FFFE,
    parameter logic [NCODES-1:0] IMM_MASK = 64'h0000_00FF_0000_0000,
    parameter logic [NCODES-1:0] T3_MASK  = 64'hF000_0000_0000_0000
) (
    input  logic [FUNC_W-1:0] func_i,
    output cls_e              cls_o
);
    always_comb begin
        if (T3_MASK[func_i])
            cls_o = CLS_TRI;
        else if (IMM_MASK[func_i])
            cls_o = CLS_IMM;
        else if (T1_MASK[func_i])
            cls_o = CLS_PAGED;
        else
            cls_o = CLS_FIXED;
    end
endmodule

// File: rtl/aeag_bank_reg.sv
module aeag_bank_reg
    import aeag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we_i,
    input  bankreg_t wdata_i,
    output bankreg_t sr_o
);
    bankreg_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (we_i)
            sr_d = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else
            sr_q <= sr_d;
    end

    assign sr_o = sr_q;

    AST_SR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (sr_o == $past(wdata_i))); // R7
    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(sr_o)); // R7
endmodule

// File: rtl/aeag_page_mux.sv
module aeag_page_mux
    import aeag_pkg::*;
(
    input  cls_e               cls_i,
    input  bankreg_t           sr_i,
    input  logic [WORD_W-1:0]  instr_i,
    input  logic [PAGE_W-1:0]  iar_page_i,
    output logic [EA_W-1:0]    ea_o,
    output logic               addr_valid_o,
    output logic [FIELD_W-1:0] imm_o,
    output logic               imm_valid_o,
    output logic               is_type3_o,
    output logic [SUB_W-1:0]   t3_minor_o,
    output logic [SUB_W-1:0]   t3_data_o
);
    logic [FIELD_W-1:0] field;
    logic [PAGE_W-1:0]  page;

    assign field = instr_i[FIELD_W-1:0];

    always_comb begin
        page         = iar_page_i;
        ea_o         = '0;
        addr_valid_o = 1'b0;
        imm_o        = '0;
        imm_valid_o  = 1'b0;
        is_type3_o   = 1'b0;
        t3_minor_o   = '0;
        t3_data_o    = '0;
        unique case (cls_i)
            CLS_PAGED: begin
                if (sr_i.ctl)
                    page = sr_i.bank;
                ea_o         = {page, field};
                addr_valid_o = 1'b1;
            end
            CLS_FIXED: begin
                ea_o         = {page, field};
                addr_valid_o = 1'b1;
            end
            CLS_IMM: begin
                imm_o       = field;
                imm_valid_o = 1'b1;
            end
            CLS_TRI: begin
                is_type3_o = 1'b1;
                t3_minor_o = field[FIELD_W-1:SUB_W];
                t3_data_o  = field[SUB_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/aeag_top.sv
module aeag_top
    import aeag_pkg::*;
#(
    parameter logic [NCODES-1:0] T1_MASK  = 64'h0000_0000_FFFF_FFFE,
    parameter logic [NCODES-1:0] IMM_MASK = 64'h0000_00FF_0000_0000,
    parameter logic [NCODES-1:0] T3_MASK  = 64'hF000_0000_0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  instr_i,
    input  logic [EA_W-1:0]    iar_i,
    input  logic               sr_we_i,
    input  logic [5:0]         sr_wdata_i,
    output logic [EA_W-1:0]    ea_o,
    output logic               addr_valid_o,
    output logic [FIELD_W-1:0] imm_o,
    output logic               imm_valid_o,
    output logic               is_type3_o,
    output logic [SUB_W-1:0]   t3_minor_o,
    output logic [SUB_W-1:0]   t3_data_o
);
    cls_e     cls;
    bankreg_t sr;
    logic     unused_iar;

    assign unused_iar = ^iar_i[FIELD_W-1:0];

    aeag_classify #(
        .T1_MASK (T1_MASK),
        .IMM_MASK(IMM_MASK),
        .T3_MASK (T3_MASK)
    ) u_cls (
        .func_i(instr_i[WORD_W-1:FIELD_W]),
        .cls_o (cls)
    );

    aeag_bank_reg u_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (sr_we_i),
        .wdata_i(bankreg_t'(sr_wdata_i)),
        .sr_o   (sr)
    );

    aeag_page_mux u_mux (
        .cls_i       (cls),
        .sr_i        (sr),
        .instr_i     (instr_i),
        .iar_page_i  (iar_i[EA_W-1:FIELD_W]),
        .ea_o        (ea_o),
        .addr_valid_o(addr_valid_o),
        .imm_o       (imm_o),
        .imm_valid_o (imm_valid_o),
        .is_type3_o  (is_type3_o),
        .t3_minor_o  (t3_minor_o),
        .t3_data_o   (t3_data_o)
    );

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({addr_valid_o, imm_valid_o, is_type3_o}) == 1); // R8
    AST_BANK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_PAGED && sr.ctl) |-> (ea_o[EA_W-1:FIELD_W] == sr.bank)); // R2
    AST_FIXED_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_FIXED) |-> (ea_o[EA_W-1:FIELD_W] == iar_i[EA_W-1:FIELD_W])); // R4
    AST_FIELD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> (ea_o[FIELD_W-1:0] == instr_i[FIELD_W-1:0])); // R3
    AST_IMM_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        imm_valid_o |-> (ea_o == '0 && imm_o == instr_i[FIELD_W-1:0])); // R5
    AST_TRI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_type3_o |-> (ea_o == '0 && imm_o == '0)); // R6
endmodule

// File: tb/sim_aeag_top.sv
module sim_aeag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] instr = '0;
    logic [16:0] iar = '0;
    logic        we = 1'b0;
    logic [5:0]  wd = '0;
    logic [16:0] ea;
    logic        av, iv, t3;
    logic [11:0] imm;
    logic [5:0]  mn, dt;

    int checks = 0;
    int errors = 0;
    int msr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aeag_top u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .iar_i(iar),
        .sr_we_i(we), .sr_wdata_i(wd), .ea_o(ea), .addr_valid_o(av),
        .imm_o(imm), .imm_valid_o(iv), .is_type3_o(t3),
        .t3_minor_o(mn), .t3_data_o(dt)
    );

    // 0 paged, 1 fixed, 2 immediate, 3 three-field (R1 defaults)
    function automatic int classof(int code);
        if (code >= 60) return 3;
        if (code >= 32 && code <= 39) return 2;
        if (code >= 1 && code <= 31) return 1 - 1;
        return 1;
    endfunction

    task automatic check(string tag);
        int code, cl, field, page, e_ea, e_av, e_iv, e_t3, e_imm, e_mn, e_dt;
        logic [5:0] got_v, exp_v;
        code  = int'(instr[17:12]);
        field = int'(instr[11:0]);
        cl    = classof(code);
        e_ea = 0; e_av = 0; e_iv = 0; e_t3 = 0; e_imm = 0; e_mn = 0; e_dt = 0;
        page = int'(iar[16:12]);
        if (cl == 0 && msr >= 32) page = msr % 32;
        if (cl <= 1) begin e_av = 1; e_ea = page * 4096 + field; end
        if (cl == 2) begin e_iv = 1; e_imm = field; end
        if (cl == 3) begin e_t3 = 1; e_mn = field / 64; e_dt = field % 64; end
        checks++;
        got_v = {av, iv, t3, 3'b0};
        exp_v = {e_av[0], e_iv[0], e_t3[0], 3'b0};
        if (got_v != exp_v || int'(ea) != e_ea || int'(imm) != e_imm
            || int'(mn) != e_mn || int'(dt) != e_dt) begin
            errors++;
            $display("FAIL %s: code=%0d ea=%h exp=%h flags=%b exp=%b imm=%h exp=%h minor=%h exp=%h data=%h exp=%h",
                     tag, code, ea, e_ea, got_v[5:3], exp_v[5:3], imm, e_imm, mn, e_mn, dt, e_dt);
        end
    endtask

    function automatic string tagof(int code);
        int cl;
        cl = classof(code);
        if (cl == 3) return "R6";
        if (cl == 2) return "R5";
        if (cl == 1) return "R4";
        return (msr >= 32) ? "R2" : "R3";
    endfunction

    task automatic step(logic [17:0] i, logic [16:0] a, logic w, logic [5:0] d, string tag);
        @(negedge clk);
        instr = i; iar = a; we = w; wd = d;
        #1;
        check(tag == "" ? tagof(int'(i[17:12])) : tag);
        @(posedge clk);
        if (w) msr = int'(d);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // reset state: bank register is 0, so paged code takes the IAR page
        @(negedge clk);
        instr = {6'd5, 12'hABC}; iar = 17'h1F000; #1;
        check("R7 reset");
        rst_n = 1'b1;
        // write arriving with this instruction must not affect it (R7)
        step({6'd5, 12'h123}, 17'h0A000, 1'b1, 6'h2D, "R7 write next cycle");
        step({6'd5, 12'h123}, 17'h0A000, 1'b0, 6'h00, "R2 bank page");
        step({6'd45, 12'h456}, 17'h05000, 1'b0, 6'h00, "R4 fixed ignores bank");
        step({6'd0, 12'h001}, 17'h13000, 1'b0, 6'h00, "R1 code 0 fixed");
        step({6'd31, 12'hFFF}, 17'h00000, 1'b0, 6'h00, "R1 code 31 paged R2");
        step({6'd32, 12'h7E5}, 17'h1F000, 1'b0, 6'h00, "R5 immediate low edge");
        step({6'd39, 12'h0F0}, 17'h1F000, 1'b0, 6'h00, "R5 immediate high edge");
        step({6'd40, 12'h3AA}, 17'h09000, 1'b0, 6'h00, "R1 code 40 fixed");
        step({6'd60, 12'hFC3}, 17'h1F000, 1'b0, 6'h00, "R6 three-field");
        step({6'd63, 12'h041}, 17'h1F000, 1'b1, 6'h1F, "R6 three-field top");
        step({6'd7, 12'h222}, 17'h0C000, 1'b0, 6'h00, "R3 flag clear");
        step({6'd7, 12'h222}, 17'h0D000, 1'b0, 6'h00, "R7 hold");
        for (int n = 0; n < 3000; n++) begin
            logic [17:0] ri;
            logic [16:0] ra;
            logic rw;
            logic [5:0] rd;
            ri = 18'($urandom);
            ra = 17'($urandom);
            rw = ($urandom % 3) == 0;
            rd = 6'($urandom);
            step(ri, ra, rw, rd, "");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: expired, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule